// File: doc/BRIEF.md
# Multi-Channel Receive Burst Scheduler

This block sits on the physical-layer side of a packet receive interface and decides which per-channel receive FIFO is drained toward the link layer next. It watches every channel's fill count and whether that channel holds an end-of-packet word. A channel with enough words, or with a complete packet end, becomes eligible. Eligible channels are served in round-robin order.

Each time a channel is chosen, the block first spends one bus cycle presenting the channel number in-band. That cycle is flagged by a start-transfer strobe. A burst of data words follows, flagged by data-valid. The burst stops at the programmed burst length, at an end-of-packet word, or when the chosen FIFO runs dry, whichever comes first. Data words carry start-of-packet and end-of-packet markers, a byte-count modulo field on the packet's last word, and odd parity.

The link layer can stall the bus at any time by lowering its enable input. The FIFOs are seen only through fill and end-of-packet status lines and a single shared first-word-fall-through read port. The block picks which channel that read port shows.

Top module: `rx_burst_sched`

## Requirements
- R1: A channel is eligible when its fill count is at least `cfg_threshold` (set to 1 or more), or when its `ch_has_eop` bit is high. A channel below threshold that holds no packet end is never selected.
- R2: Each selection starts with one address cycle: `rx_sx`=1, `rx_val`=0 and `rx_data` holding the channel number zero-extended. The selected channel's first data word comes in the very next enabled cycle.
- R3: A selection sends at most `cfg_burst_len` data words. A value of 0 behaves as 1. When the limit is reached and the channel is still eligible, a fresh address cycle follows.
- R4: A data word whose FIFO end-of-packet flag is set ends the burst at once, whatever burst length remains. That word drives `rx_eop`=1 and passes the FIFO's modulo value on `rx_mod`. Every other data word drives `rx_mod`=0.
- R5: Eligible channels are granted in round-robin order, starting with the channel after the one last granted and wrapping from the highest number to 0.
- R6: If `rx_enb` is low at a rising edge, the cycle that follows shows `rx_val`=0 and `rx_sx`=0 and the scheduler state does not move. Once enable returns, the data stream goes on with no word lost or repeated.
- R7: `rx_prty` gives odd parity over `rx_data`: the count of ones in `rx_data` plus `rx_prty` is odd on every address or data cycle.
- R8: While no channel is eligible, the bus stays idle with `rx_val`=0 and `rx_sx`=0.
- R9: `rx_sop` and `rx_eop` on a data word copy the FIFO's start and end flags for that word, so the first word of a packet carries `rx_sop`=1.
- R10: While `rst_n` is low, all bus outputs stay 0 even when channels are eligible. After reset the round-robin pointer starts at the highest channel, so channel 0 wins the first grant.
- R11: If the selected FIFO is empty in a data cycle, the burst ends with an idle cycle and no read strobe is issued to the empty FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_threshold | input | FILL_W | Fill count that makes a channel eligible |
| cfg_burst_len | input | BL_W | Maximum data words per selection (0 acts as 1) |
| ch_fill | input | NUM_CH*FILL_W | Fill count of each channel, channel 0 in the low bits |
| ch_has_eop | input | NUM_CH | Channel holds at least one end-of-packet word |
| fifo_rd_sel | output | IDX_W | Channel shown on the shared read port |
| fifo_rd_en | output | 1 | Pop the head word of the selected FIFO at this edge |
| fifo_rd_data | input | DATA_W | Head word of the selected FIFO |
| fifo_rd_sop | input | 1 | Head word starts a packet |
| fifo_rd_eop | input | 1 | Head word ends a packet |
| fifo_rd_mod | input | MOD_W | Modulo byte count of the head word |
| rx_enb | input | 1 | Link-layer enable; low stalls the bus |
| rx_data | output | DATA_W | Channel number in an address cycle, otherwise data |
| rx_sx | output | 1 | Address-cycle strobe |
| rx_val | output | 1 | Data word valid |
| rx_sop | output | 1 | Start of packet |
| rx_eop | output | 1 | End of packet |
| rx_mod | output | MOD_W | Modulo byte count on the end-of-packet word |
| rx_prty | output | 1 | Odd parity over rx_data |

## Verification
The scheduler is driven with several input patterns:
- A single channel held just under threshold and then raised to it, which tells a fill-based grant apart from no grant.
- A short terminated packet followed by a trailing partial packet, which tells an end-of-packet grant and an early burst end apart from a length-limited burst.
- One long channel under burst lengths 3 and 0, which shows length slicing with fresh address cycles.
- Three channels with data at once, which shows the round-robin order and its wrap.
- An irregular stall pattern on `rx_enb` during a long burst, which shows whether a stall loses or duplicates words.

Every emitted word is matched against the head of a FIFO model, so ordering errors show up in any of these patterns.

// File: rtl/rx_sched_pkg.sv
// Shared types and helpers for the receive burst scheduler.
// Assumes nothing beyond IEEE 1800-2017 packages.
package rx_sched_pkg;

    // Scheduler phase: waiting to select, or streaming a burst.
    typedef enum logic {
        SCH_WAIT  = 1'b0,
        SCH_BURST = 1'b1
    } sch_state_e;

    // Odd parity bit for a word of any width up to 32 bits.
    function automatic logic odd_par(input logic [31:0] w);
        return ~(^w);
    endfunction

endpackage

// File: rtl/rx_sched_elig.sv
// Per-channel eligibility: a channel may be served when its fill
// reaches the threshold or it holds a packet end.
// Assumes cfg_threshold is nonzero; fill counts are unsigned.
module rx_sched_elig #(
    parameter int NUM_CH = 4,
    parameter int FILL_W = 8
) (
    input  logic [NUM_CH*FILL_W-1:0] ch_fill,
    input  logic [NUM_CH-1:0]        ch_has_eop,
    input  logic [FILL_W-1:0]        cfg_threshold,
    output logic [NUM_CH-1:0]        elig
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
            // Compare one channel's fill with the threshold.
            assign elig[gi] = (ch_fill[gi*FILL_W +: FILL_W] >= cfg_threshold)
                              || ch_has_eop[gi];
        end
    endgenerate

endmodule

// File: rtl/rx_sched_rr.sv
// Round-robin picker: finds the first eligible channel after last_idx,
// wrapping at NUM_CH. Purely combinational.
// Assumes last_idx < NUM_CH.
module rx_sched_rr #(
    parameter int NUM_CH = 4,
    parameter int IDX_W  = 2
) (
    input  logic [NUM_CH-1:0] elig,
    input  logic [IDX_W-1:0]  last_idx,
    output logic [IDX_W-1:0]  grant_idx,
    output logic              grant_any
);

    // Scan candidates in rotating order starting one past last_idx.
    always_comb begin
        grant_idx = '0;
        grant_any = 1'b0;
        for (int off = 1; off <= NUM_CH; off++) begin
            int cand;
            cand = int'(last_idx) + off;
            if (cand >= NUM_CH) cand = cand - NUM_CH;
            if (!grant_any && elig[cand]) begin
                grant_any = 1'b1;
                grant_idx = IDX_W'(cand);
            end
        end
    end

endmodule

// File: rtl/rx_sched_out.sv
// Output register stage: holds one bus cycle (address, data or idle)
// and adds odd parity. All outputs clear under reset.
// Assumes the caller never requests address and data in one cycle.
module rx_sched_out #(
    parameter int DATA_W = 32,
    parameter int MOD_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nxt_sx,
    input  logic              nxt_val,
    input  logic [DATA_W-1:0] nxt_data,
    input  logic              nxt_sop,
    input  logic              nxt_eop,
    input  logic [MOD_W-1:0]  nxt_mod,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_sx,
    output logic              rx_val,
    output logic              rx_sop,
    output logic              rx_eop,
    output logic [MOD_W-1:0]  rx_mod,
    output logic              rx_prty
);
    import rx_sched_pkg::*;

    // Register the next bus cycle and its parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_sx   <= 1'b0;
            rx_val  <= 1'b0;
            rx_sop  <= 1'b0;
            rx_eop  <= 1'b0;
            rx_mod  <= '0;
            rx_prty <= 1'b0;
        end else begin
            rx_data <= nxt_data;
            rx_sx   <= nxt_sx;
            rx_val  <= nxt_val;
            rx_sop  <= nxt_sop;
            rx_eop  <= nxt_eop;
            rx_mod  <= nxt_mod;
            rx_prty <= odd_par(32'(nxt_data));
        end
    end

    AST_SX_VAL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_sx && rx_val));                                   // R2
    AST_EOP_NEEDS_VAL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_eop || rx_sop) |-> rx_val);                        // R9
    AST_MOD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_val && !rx_eop) |-> (rx_mod == '0));               // R4

endmodule

// File: rtl/rx_burst_sched.sv
// Receive burst scheduler top. Picks an eligible channel round-robin,
// emits an address cycle, then streams up to cfg_burst_len words from
// the shared FIFO read port, stopping early at a packet end or an
// empty FIFO. rx_enb low freezes the scheduler and idles the bus.
// Assumes: first-word-fall-through FIFO read port muxed by fifo_rd_sel,
// fill counts that reflect pops before the next edge, and configuration
// that stays stable while a burst is in flight.
module rx_burst_sched #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32,
    parameter int FILL_W = 8,
    parameter int BL_W   = 8,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int MOD_W = (DATA_W > 8) ? $clog2(DATA_W / 8) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [FILL_W-1:0]        cfg_threshold,
    input  logic [BL_W-1:0]          cfg_burst_len,
    input  logic [NUM_CH*FILL_W-1:0] ch_fill,
    input  logic [NUM_CH-1:0]        ch_has_eop,
    output logic [IDX_W-1:0]         fifo_rd_sel,
    output logic                     fifo_rd_en,
    input  logic [DATA_W-1:0]        fifo_rd_data,
    input  logic                     fifo_rd_sop,
    input  logic                     fifo_rd_eop,
    input  logic [MOD_W-1:0]         fifo_rd_mod,
    input  logic                     rx_enb,
    output logic [DATA_W-1:0]        rx_data,
    output logic                     rx_sx,
    output logic                     rx_val,
    output logic                     rx_sop,
    output logic                     rx_eop,
    output logic [MOD_W-1:0]         rx_mod,
    output logic                     rx_prty
);
    import rx_sched_pkg::*;

    localparam logic [IDX_W-1:0] LAST_CH = IDX_W'(NUM_CH - 1);

    sch_state_e        st_q, st_d;
    logic [IDX_W-1:0]  sel_q, sel_d;
    logic [IDX_W-1:0]  last_q, last_d;
    logic [BL_W-1:0]   cnt_q, cnt_d;
    logic [NUM_CH-1:0] elig;
    logic [IDX_W-1:0]  grant_idx;
    logic              grant_any;
    logic [FILL_W-1:0] sel_fill;
    logic              sel_nonempty;
    logic              burst_full;
    logic              nxt_sx, nxt_val, nxt_sop, nxt_eop;
    logic [DATA_W-1:0] nxt_data;
    logic [MOD_W-1:0]  nxt_mod;

    rx_sched_elig #(.NUM_CH(NUM_CH), .FILL_W(FILL_W)) elig_i (
        .ch_fill       (ch_fill),
        .ch_has_eop    (ch_has_eop),
        .cfg_threshold (cfg_threshold),
        .elig          (elig)
    );

    rx_sched_rr #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) rr_i (
        .elig      (elig),
        .last_idx  (last_q),
        .grant_idx (grant_idx),
        .grant_any (grant_any)
    );

    // Fill and burst-limit status of the channel being drained.
    assign sel_fill     = ch_fill[sel_q*FILL_W +: FILL_W];
    assign sel_nonempty = (sel_fill != '0);
    assign burst_full   = ({1'b0, cnt_q} + (BL_W+1)'(1)) >= {1'b0, cfg_burst_len};
    assign fifo_rd_sel  = sel_q;

    // Next-state and next-bus-cycle decision.
    always_comb begin
        st_d       = st_q;
        sel_d      = sel_q;
        last_d     = last_q;
        cnt_d      = cnt_q;
        fifo_rd_en = 1'b0;
        nxt_sx     = 1'b0;
        nxt_val    = 1'b0;
        nxt_sop    = 1'b0;
        nxt_eop    = 1'b0;
        nxt_data   = '0;
        nxt_mod    = '0;
        if (rx_enb) begin
            case (st_q)
                SCH_WAIT: begin
                    if (grant_any) begin
                        nxt_sx   = 1'b1;
                        nxt_data = DATA_W'(grant_idx);
                        sel_d    = grant_idx;
                        last_d   = grant_idx;
                        cnt_d    = '0;
                        st_d     = SCH_BURST;
                    end
                end
                SCH_BURST: begin
                    if (sel_nonempty) begin
                        fifo_rd_en = 1'b1;
                        nxt_val    = 1'b1;
                        nxt_data   = fifo_rd_data;
                        nxt_sop    = fifo_rd_sop;
                        nxt_eop    = fifo_rd_eop;
                        nxt_mod    = fifo_rd_eop ? fifo_rd_mod : '0;
                        cnt_d      = cnt_q + BL_W'(1);
                        if (fifo_rd_eop || burst_full) st_d = SCH_WAIT;
                    end else begin
                        st_d = SCH_WAIT;
                    end
                end
                default: st_d = SCH_WAIT;
            endcase
        end
    end

    // Scheduler state registers; pointer starts at the top channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SCH_WAIT;
            sel_q  <= '0;
            last_q <= LAST_CH;
            cnt_q  <= '0;
        end else begin
            st_q   <= st_d;
            sel_q  <= sel_d;
            last_q <= last_d;
            cnt_q  <= cnt_d;
        end
    end

    rx_sched_out #(.DATA_W(DATA_W), .MOD_W(MOD_W)) out_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .nxt_sx   (nxt_sx),
        .nxt_val  (nxt_val),
        .nxt_data (nxt_data),
        .nxt_sop  (nxt_sop),
        .nxt_eop  (nxt_eop),
        .nxt_mod  (nxt_mod),
        .rx_data  (rx_data),
        .rx_sx    (rx_sx),
        .rx_val   (rx_val),
        .rx_sop   (rx_sop),
        .rx_eop   (rx_eop),
        .rx_mod   (rx_mod),
        .rx_prty  (rx_prty)
    );

    AST_PAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enb |=> (!rx_val && !rx_sx));                      // R6
    AST_NO_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_en |-> sel_nonempty);                          // R11
    AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SCH_BURST && cfg_burst_len != '0) |-> (cnt_q < cfg_burst_len)); // R3
    AST_EOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_val && rx_eop) |-> (st_q == SCH_WAIT));            // R4
    AST_IDLE_WHEN_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SCH_WAIT && !grant_any) |=> (!rx_val && !rx_sx)); // R8
    AST_ADDR_THEN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sx |-> (st_q == SCH_BURST && rx_data == DATA_W'(sel_q))); // R2

endmodule

// File: tb/rx_burst_sched_tb_top.sv
// Directed bench for rx_burst_sched: per-channel FIFO model, bus monitor
// matching each data word against the FIFO head, one task per scenario.
`timescale 1ns/100ps
module rx_burst_sched_tb_top;

    localparam int NUM_CH = 4;
    localparam int DATA_W = 32;
    localparam int FILL_W = 8;
    localparam int BL_W   = 8;
    localparam int IDX_W  = 2;
    localparam int MOD_W  = 2;
    localparam int EW     = DATA_W + MOD_W + 2;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [FILL_W-1:0]        cfg_threshold = 8'd1;
    logic [BL_W-1:0]          cfg_burst_len = 8'd4;
    logic [NUM_CH*FILL_W-1:0] ch_fill;
    logic [NUM_CH-1:0]        ch_has_eop;
    logic [IDX_W-1:0]         fifo_rd_sel;
    logic                     fifo_rd_en;
    logic [DATA_W-1:0]        fifo_rd_data;
    logic                     fifo_rd_sop, fifo_rd_eop;
    logic [MOD_W-1:0]         fifo_rd_mod;
    logic                     rx_enb = 1'b1;
    logic [DATA_W-1:0]        rx_data;
    logic                     rx_sx, rx_val, rx_sop, rx_eop, rx_prty;
    logic [MOD_W-1:0]         rx_mod;

    int total = 0;
    int bad   = 0;

    // FIFO model: entry = {sop, eop, mod, data}
    logic [EW-1:0] fq [NUM_CH][$];
    logic [EW-1:0] head_w [NUM_CH];
    int            cur_ch = 0;

    // Log of non-idle bus cycles
    bit          lg_addr [256];
    logic [31:0] lg_data [256];
    bit          lg_sop  [256];
    bit          lg_eop  [256];
    logic [1:0]  lg_mod  [256];
    int          lg_n = 0;

    always #2.5 clk = ~clk;

    assign {fifo_rd_sop, fifo_rd_eop, fifo_rd_mod, fifo_rd_data} = head_w[fifo_rd_sel];

    rx_burst_sched #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .FILL_W(FILL_W), .BL_W(BL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_threshold(cfg_threshold), .cfg_burst_len(cfg_burst_len),
        .ch_fill(ch_fill), .ch_has_eop(ch_has_eop), .fifo_rd_sel(fifo_rd_sel),
        .fifo_rd_en(fifo_rd_en), .fifo_rd_data(fifo_rd_data), .fifo_rd_sop(fifo_rd_sop),
        .fifo_rd_eop(fifo_rd_eop), .fifo_rd_mod(fifo_rd_mod), .rx_enb(rx_enb),
        .rx_data(rx_data), .rx_sx(rx_sx), .rx_val(rx_val), .rx_sop(rx_sop),
        .rx_eop(rx_eop), .rx_mod(rx_mod), .rx_prty(rx_prty)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic update_drives();
        for (int c = 0; c < NUM_CH; c++) begin
            bit e = 1'b0;
            ch_fill[c*FILL_W +: FILL_W] = FILL_W'(fq[c].size());
            foreach (fq[c][k]) if (fq[c][k][EW-2]) e = 1'b1;
            ch_has_eop[c] = e;
            head_w[c] = (fq[c].size() > 0) ? fq[c][0] : '0;
        end
    endtask

    // Push one word; non-end words carry a junk modulo the design must clear.
    task automatic push(input int c, input logic [31:0] d, input bit sop, input bit eop, input logic [1:0] m);
        fq[c].push_back({sop, eop, (eop ? m : 2'd2), d});
        update_drives();
    endtask

    // Bus monitor: logs cycles, checks parity, stall idling and word order.
    initial begin
        update_drives();
        forever begin
            @(negedge clk);
            if (rst_n && (rx_val || rx_sx)) begin
                chk((^rx_data ^ rx_prty) == 1'b1, "R7 odd parity", {31'd0, rx_prty}, {31'd0, ~(^rx_data)});
                if (lg_n < 256) begin
                    lg_addr[lg_n] = rx_sx; lg_data[lg_n] = rx_data;
                    lg_sop[lg_n] = rx_sop; lg_eop[lg_n] = rx_eop; lg_mod[lg_n] = rx_mod;
                    lg_n++;
                end
                if (rx_sx) cur_ch = int'(rx_data);
                if (rx_val) begin
                    if (fq[cur_ch].size() == 0) begin
                        chk(1'b0, "R6 word with no FIFO entry", rx_data, 32'hffffffff);
                    end else begin
                        logic [EW-1:0] e;
                        e = fq[cur_ch].pop_front();
                        chk(rx_data == e[DATA_W-1:0] && rx_sop == e[EW-1] && rx_eop == e[EW-2]
                            && rx_mod == (e[EW-2] ? e[DATA_W +: MOD_W] : 2'd0),
                            "R6 R9 R4 word order and flags", {rx_sop, rx_eop, rx_mod, rx_data[27:0]},
                            {e[EW-1], e[EW-2], (e[EW-2] ? e[DATA_W +: MOD_W] : 2'd0), e[27:0]});
                        update_drives();
                    end
                end
            end
            if (rst_n && !rx_enb)
                chk(!rx_val && !rx_sx, "R6 idle after stall edge", {30'd0, rx_val, rx_sx}, 32'd0);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk); #1;
        rst_n = 1'b0;
        rx_enb = 1'b1;
        for (int c = 0; c < NUM_CH; c++) fq[c].delete();
        update_drives();
        wait_cyc(3);
        lg_n = 0;
        rst_n = 1'b1;
    endtask

    task automatic exp_log(input int i, input bit is_addr, input logic [31:0] d, input string req);
        chk(i < lg_n && lg_addr[i] == is_addr && lg_data[i] == d, req, lg_data[i], d);
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        rst_n = 1'b0;
        push(2, 32'h0200_0000, 1, 0, 0);
        push(0, 32'h0000_0000, 1, 1, 1);
        cfg_threshold = 1; cfg_burst_len = 4;
        wait_cyc(4);
        chk(!rx_val && !rx_sx && rx_data == 0, "R10 outputs low in reset", {30'd0, rx_val, rx_sx}, 0);
        lg_n = 0;
        rst_n = 1'b1;
        wait_cyc(8);
        exp_log(0, 1, 32'd0, "R10 channel 0 granted first");
        exp_log(2, 1, 32'd2, "R5 then channel 2");
    endtask

    task automatic t_idle();
        do_reset();
        wait_cyc(6);
        chk(lg_n == 0 && !rx_val && !rx_sx, "R8 idle with no eligible channel", lg_n, 0);
    endtask

    task automatic t_threshold();
        do_reset();
        cfg_threshold = 4; cfg_burst_len = 8;
        for (int k = 0; k < 3; k++) push(1, 32'h0100_0000 + k, (k == 0), 0, 0);
        wait_cyc(8);
        chk(lg_n == 0, "R1 below threshold not served", lg_n, 0);
        push(1, 32'h0100_0003, 0, 0, 0);
        wait_cyc(10);
        exp_log(0, 1, 32'd1, "R2 address cycle carries channel");
        exp_log(1, 0, 32'h0100_0000, "R2 first data right after address");
        chk(lg_n == 5, "R11 burst ends when FIFO empties", lg_n, 5);
        chk(fq[1].size() == 0, "R1 all words drained at threshold", fq[1].size(), 0);
    endtask

    task automatic t_eop();
        do_reset();
        cfg_threshold = 16; cfg_burst_len = 8;
        push(2, 32'h0200_0000, 1, 0, 0);
        push(2, 32'h0200_0001, 0, 1, 3);
        for (int k = 2; k < 5; k++) push(2, 32'h0200_0000 + k, (k == 2), 0, 0);
        wait_cyc(12);
        chk(lg_n == 3, "R4 burst ends at end of packet", lg_n, 3);
        chk(lg_sop[1] == 1'b1, "R9 sop on first packet word", {31'd0, lg_sop[1]}, 1);
        chk(lg_eop[2] == 1'b1 && lg_mod[2] == 2'd3, "R4 eop word carries modulo", {lg_eop[2], lg_mod[2]}, {1'b1, 2'd3});
        chk(fq[2].size() == 3, "R1 trailing partial packet not served", fq[2].size(), 3);
    endtask

    task automatic t_burst();
        do_reset();
        cfg_threshold = 1; cfg_burst_len = 3;
        for (int k = 0; k < 7; k++) push(0, 32'h0000_0100 + k, (k == 0), 0, 0);
        wait_cyc(20);
        chk(lg_n == 10, "R3 three slices for seven words", lg_n, 10);
        exp_log(4, 1, 32'd0, "R3 new address after burst limit");
        exp_log(8, 1, 32'd0, "R3 third address cycle");
        do_reset();
        cfg_threshold = 1; cfg_burst_len = 0;
        push(1, 32'h0100_0aa0, 1, 0, 0);
        push(1, 32'h0100_0aa1, 0, 0, 0);
        wait_cyc(10);
        chk(lg_n == 4, "R3 zero length acts as one", lg_n, 4);
        exp_log(2, 1, 32'd1, "R3 re-address after single word");
    endtask

    task automatic t_rr();
        int ord [6] = '{0, 1, 3, 0, 1, 3};
        do_reset();
        cfg_threshold = 1; cfg_burst_len = 1;
        for (int k = 0; k < 2; k++) begin
            push(0, 32'h0000_0010 + k, 0, 0, 0);
            push(1, 32'h0100_0010 + k, 0, 0, 0);
            push(3, 32'h0300_0010 + k, 0, 0, 0);
        end
        wait_cyc(20);
        chk(lg_n == 12, "R5 six grants", lg_n, 12);
        for (int g = 0; g < 6; g++) exp_log(2 * g, 1, ord[g], "R5 round-robin order");
    endtask

    task automatic t_pause();
        bit [15:0] pat = 16'b1011_0010_1101_0110;
        do_reset();
        cfg_threshold = 1; cfg_burst_len = 8;
        for (int k = 0; k < 6; k++) push(2, 32'h0200_0500 + k, (k == 0), (k == 5), 1);
        for (int i = 0; i < 16; i++) begin
            rx_enb = pat[i];
            wait_cyc(1);
        end
        rx_enb = 1'b1;
        wait_cyc(10);
        chk(lg_n == 7, "R6 all words after stalls", lg_n, 7);
        chk(fq[2].size() == 0, "R6 FIFO drained exactly", fq[2].size(), 0);
        exp_log(6, 0, 32'h0200_0505, "R6 last word in place");
    endtask

    initial begin
        #(200000 * 5);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        update_drives();
        t_reset();
        t_idle();
        t_threshold();
        t_eop();
        t_burst();
        t_rr();
        t_pause();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule